// File: doc/BRIEF.md
# 40-bit Multiply-Accumulate Coprocessor Unit

This unit is a small DSP coprocessor that keeps one private 40-bit accumulator. It does not work on a general register. Each accepted operation either adds a signed product into that accumulator, loads the accumulator from two source words, or copies it out as a pair of 32-bit words. The unit offers three product forms: a full 32x32 word product, a packed form that adds two halfword products at once, and a form that picks one halfword from each operand. All accumulation keeps the low 40 bits and wraps around. It never saturates.

A host pipeline gives the unit an operation code, two 32-bit source operands and a valid strobe. It also gives the unit the current value of a separate access-control register. Bit 0 of that register grants use of the unit. When the unit is not granted, or when the operation code is not assigned, the unit raises a one-cycle undefined-instruction flag in place of the operation. A read followed later by a write of the same two words restores the accumulator exactly, so a context switch can save and restore it.

Top module: `mac40_unit`

## Requirements
- R1: After synchronous active-low reset the accumulator is zero, and `undef_exc` and `rd_valid` are low.
- R2: Operation code 0 (full word) adds the signed product src_a × src_b to the accumulator and keeps the low 40 bits.
- R3: Operation code 1 (packed) adds the two signed products src_a[15:0]×src_b[15:0] and src_a[31:16]×src_b[31:16] in one operation.
- R4: Operation code 2 (halfword select) adds one signed 16x16 product. `sel_top_a`=1 selects src_a[31:16] and 0 selects src_a[15:0]. `sel_top_b` selects the half of src_b in the same way.
- R5: Operation code 3 (load) sets accumulator bits 31:0 from src_a and bits 39:32 from src_b[7:0].
- R6: Operation code 4 (read) pulses `rd_valid` one cycle later. In that cycle `rd_lo` holds accumulator bits 31:0 and `rd_hi` holds bits 39:32 sign-extended to 32 bits. `rd_lo` and `rd_hi` keep these values until the next read.
- R7: When `access_reg[0]` is 0, any valid operation raises `undef_exc` for exactly the next cycle, leaves the accumulator unchanged and gives no `rd_valid`.
- R8: Operation codes 5, 6 and 7 are unassigned. Even when access is granted they raise `undef_exc` one cycle later and leave the accumulator unchanged.
- R9: In a cycle where `op_valid` is low, the accumulator holds its value, and `undef_exc` and `rd_valid` are low in the following cycle.
- R10: Accumulation wraps modulo 2^40. For example, 0x7F_FFFF_FFFF plus a product of 1 gives 0x80_0000_0000.
- R11: After a read, loading the returned `rd_lo` and the low byte of `rd_hi` restores the accumulator bit for bit.
- R12: Only bit 0 of `access_reg` affects behaviour. The other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 3 | Operation selector (0..4 assigned, 5..7 unassigned) |
| sel_top_a | input | 1 | Halfword select for src_a in operation 2 |
| sel_top_b | input | 1 | Halfword select for src_b in operation 2 |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| access_reg | input | 16 | Access-control register value, bit 0 grants use |
| rd_lo | output | 32 | Accumulator bits 31:0 from the last read |
| rd_hi | output | 32 | Accumulator bits 39:32, sign-extended, from the last read |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| undef_exc | output | 1 | One-cycle undefined-instruction flag |

## Verification
Every result is due exactly one clock edge after the operation is accepted. The `undef_exc` and `rd_valid` pulses and the read words appear in the cycle after the strobe, and an accumulator change becomes visible through the next read. The bench drives each operation on a falling edge and removes it on the next falling edge. It samples the flags and read words at that second falling edge, which lies one rising edge after the strobe. It checks the accumulator only through read operations, comparing against a bench model that applies the same one-edge rule.

// File: rtl/mac40_pkg.sv
// Package: shared operation encoding for the 40-bit multiply-accumulate unit.
// Assumes a 3-bit operation code; codes above OP_READ are unassigned.
package mac40_pkg;

    typedef enum logic [2:0] {
        OP_FULL = 3'd0,   // signed word x word
        OP_DUAL = 3'd1,   // two halfword products summed
        OP_HALF = 3'd2,   // one selected halfword product
        OP_LOAD = 3'd3,   // write accumulator
        OP_READ = 3'd4    // read accumulator
    } op_e;

endpackage

// File: rtl/mac40_decode.sv
// Module: mac40_decode
// Checks permission and the operation code, and raises exactly one action
// strobe per valid operation. Assumes bit 0 of access_reg is the grant bit
// and every other bit carries no meaning for this unit.
module mac40_decode
    import mac40_pkg::*;
#(
    parameter int ACR_W = 16
) (
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [ACR_W-1:0] access_reg,
    output logic             mac_en,
    output logic             load_en,
    output logic             read_en,
    output logic             undef_en,
    output op_e              kind
);

    logic granted;
    logic known;

    // Split the strobe into one action, or into the exception when blocked.
    always_comb begin
        kind     = op_e'(op_code);
        granted  = access_reg[0];
        known    = (op_code <= 3'(OP_READ));
        undef_en = op_valid && !(granted && known);
        mac_en   = 1'b0;
        load_en  = 1'b0;
        read_en  = 1'b0;
        if (op_valid && granted && known) begin
            case (kind)
                OP_FULL, OP_DUAL, OP_HALF: mac_en  = 1'b1;
                OP_LOAD:                   load_en = 1'b1;
                OP_READ:                   read_en = 1'b1;
                default:                   ;
            endcase
        end
    end

endmodule

// File: rtl/mac40_addend.sv
// Module: mac40_addend
// Builds the signed addend for the three multiply forms, sign-extended to
// the accumulator width. Assumes ACC_W >= 2*HALF_W and ACC_W <= 2*DATA_W.
module mac40_addend
    import mac40_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  op_e               kind,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              sel_top_a,
    input  logic              sel_top_b,
    output logic [ACC_W-1:0]  addend
);

    localparam int HALF_W  = DATA_W / 2;
    localparam int HPROD_W = 2 * HALF_W;
    localparam int FPROD_W = 2 * DATA_W;
    localparam int LANES   = 2;

    logic signed [DATA_W-1:0]  word_a, word_b;
    logic signed [FPROD_W-1:0] full_prod;
    logic signed [ACC_W-1:0]   lane_ext [LANES];
    logic signed [HALF_W-1:0]  pick_a, pick_b;
    logic signed [HPROD_W-1:0] pick_prod;
    logic signed [ACC_W-1:0]   pick_ext;

    // Full-word product on sign-extended operands.
    always_comb begin
        word_a    = src_a;
        word_b    = src_b;
        full_prod = FPROD_W'(word_a) * FPROD_W'(word_b);
    end

    // One signed halfword product per lane, for the packed form.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [HALF_W-1:0]  ha, hb;
        logic signed [HPROD_W-1:0] hp;
        // Multiply the matching halves of both operands.
        always_comb begin
            ha          = src_a[g*HALF_W +: HALF_W];
            hb          = src_b[g*HALF_W +: HALF_W];
            hp          = HPROD_W'(ha) * HPROD_W'(hb);
            lane_ext[g] = ACC_W'(hp);
        end
    end

    // Selected-halfword product.
    always_comb begin
        pick_a    = sel_top_a ? src_a[DATA_W-1:HALF_W] : src_a[HALF_W-1:0];
        pick_b    = sel_top_b ? src_b[DATA_W-1:HALF_W] : src_b[HALF_W-1:0];
        pick_prod = HPROD_W'(pick_a) * HPROD_W'(pick_b);
        pick_ext  = ACC_W'(pick_prod);
    end

    // Choose the addend for the current form.
    always_comb begin
        case (kind)
            OP_FULL: addend = full_prod[ACC_W-1:0];
            OP_DUAL: addend = lane_ext[0] + lane_ext[1];
            OP_HALF: addend = pick_ext;
            default: addend = '0;
        endcase
    end

endmodule

// File: rtl/mac40_acc.sv
// Module: mac40_acc
// Holds the private accumulator. It adds the addend, loads it from the two
// source words, or holds its value. Assumes at most one of mac_en and
// load_en is high in a cycle.
module mac40_acc #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_en,
    input  logic              load_en,
    input  logic [ACC_W-1:0]  addend,
    input  logic [DATA_W-1:0] load_lo,
    input  logic [DATA_W-1:0] load_hi,
    output logic [ACC_W-1:0]  acc_q
);

    localparam int GUARD_W = ACC_W - DATA_W;

    // Update the accumulator: clear, load, add with wraparound, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (load_en) acc_q <= {load_hi[GUARD_W-1:0], load_lo};
        else if (mac_en)  acc_q <= acc_q + addend;
    end

    // R1: the first cycle out of reset sees a cleared accumulator.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> acc_q == '0);

    // R5: a load places both source fields.
    p_load_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> acc_q == {$past(load_hi[GUARD_W-1:0]), $past(load_lo)});

endmodule

// File: rtl/mac40_resp.sv
// Module: mac40_resp
// Registers the response side: read words, the read pulse and the
// undefined-instruction pulse. Assumes ACC_W - DATA_W < DATA_W.
module mac40_resp #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_en,
    input  logic              undef_en,
    input  logic [ACC_W-1:0]  acc_q,
    output logic [DATA_W-1:0] rd_lo,
    output logic [DATA_W-1:0] rd_hi,
    output logic              rd_valid,
    output logic              undef_exc
);

    localparam int GUARD_W = ACC_W - DATA_W;
    localparam int EXT_W   = DATA_W - GUARD_W;

    // Register the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            undef_exc <= 1'b0;
        end else begin
            rd_valid  <= read_en;
            undef_exc <= undef_en;
        end
    end

    // Capture the read words on a read and hold them until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lo <= '0;
            rd_hi <= '0;
        end else if (read_en) begin
            rd_lo <= acc_q[DATA_W-1:0];
            rd_hi <= {{EXT_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:DATA_W]};
        end
    end

    // R6: read data matches the accumulator and the high word is a sign extension.
    p_read_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        read_en |=> rd_valid && rd_lo == $past(acc_q[DATA_W-1:0])
                    && rd_hi[GUARD_W-1:0] == $past(acc_q[ACC_W-1:DATA_W]));

    p_read_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_hi[DATA_W-1:GUARD_W-1] == '0 ||
                      rd_hi[DATA_W-1:GUARD_W-1] == '1));

    // R6: read words stay put between reads.
    p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !read_en |=> $stable(rd_lo) && $stable(rd_hi));

endmodule

// File: rtl/mac40_unit.sv
// Module: mac40_unit (top)
// A multiply-accumulate coprocessor with one private 40-bit accumulator.
// Every operation takes effect at the clock edge that samples op_valid.
// Assumes the host holds the access-control register value on access_reg.
module mac40_unit
    import mac40_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 40,
    parameter int ACR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              sel_top_a,
    input  logic              sel_top_b,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [ACR_W-1:0]  access_reg,
    output logic [DATA_W-1:0] rd_lo,
    output logic [DATA_W-1:0] rd_hi,
    output logic              rd_valid,
    output logic              undef_exc
);

    logic             mac_en, load_en, read_en, undef_en;
    op_e              kind;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] acc_q;

    mac40_decode #(.ACR_W(ACR_W)) u_decode (
        .op_valid   (op_valid),
        .op_code    (op_code),
        .access_reg (access_reg),
        .mac_en     (mac_en),
        .load_en    (load_en),
        .read_en    (read_en),
        .undef_en   (undef_en),
        .kind       (kind)
    );

    mac40_addend #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_addend (
        .kind      (kind),
        .src_a     (src_a),
        .src_b     (src_b),
        .sel_top_a (sel_top_a),
        .sel_top_b (sel_top_b),
        .addend    (addend)
    );

    mac40_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .mac_en  (mac_en),
        .load_en (load_en),
        .addend  (addend),
        .load_lo (src_a),
        .load_hi (src_b),
        .acc_q   (acc_q)
    );

    mac40_resp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .read_en   (read_en),
        .undef_en  (undef_en),
        .acc_q     (acc_q),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .rd_valid  (rd_valid),
        .undef_exc (undef_exc)
    );

    // R7: a blocked operation flags, changes nothing and gives no read pulse.
    p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !access_reg[0]) |=> undef_exc && !rd_valid && $stable(acc_q));

    // R8: an unassigned code is refused even when granted.
    p_unassigned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && access_reg[0] && op_code > 3'd4) |=> undef_exc && $stable(acc_q));

    // R9: an idle cycle changes nothing and gives no pulses.
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !undef_exc && !rd_valid && $stable(acc_q));

    // R7: a granted assigned operation never raises the flag.
    p_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && access_reg[0] && op_code <= 3'd4) |=> !undef_exc);

endmodule

// File: tb/mac40_unit_tb.sv
`timescale 1ns/1ps
module mac40_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic        sel_top_a = 1'b0, sel_top_b = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [15:0] access_reg = '0;
    logic [31:0] rd_lo, rd_hi;
    logic        rd_valid, undef_exc;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [39:0] model = '0;

    always #10 clk = ~clk;   // 50 MHz

    mac40_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .sel_top_a(sel_top_a), .sel_top_b(sel_top_b), .src_a(src_a),
        .src_b(src_b), .access_reg(access_reg), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .rd_valid(rd_valid), .undef_exc(undef_exc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Signed addend computed from the requirements with 64-bit arithmetic.
    function automatic logic [39:0] want_addend(input logic [2:0] op, input logic [31:0] a,
                                                input logic [31:0] b, input bit ta, input bit tb);
        longint p;
        logic [15:0] ha, hb;
        ha = ta ? a[31:16] : a[15:0];
        hb = tb ? b[31:16] : b[15:0];
        case (op)
            3'd0:    p = longint'(signed'(a)) * longint'(signed'(b));
            3'd1:    p = longint'(signed'(a[15:0])) * longint'(signed'(b[15:0]))
                       + longint'(signed'(a[31:16])) * longint'(signed'(b[31:16]));
            3'd2:    p = longint'(signed'(ha)) * longint'(signed'(hb));
            default: p = 0;
        endcase
        return p[39:0];
    endfunction

    function automatic logic [31:0] want_hi(input logic [39:0] v);
        return {{24{v[39]}}, v[39:32]};
    endfunction

    // Drive one operation for one cycle, then check what is due one edge later.
    task automatic run_op(input string req, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input bit ta, input bit tb,
                          input logic [15:0] acr);
        bit ok;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; src_a = a; src_b = b;
        sel_top_a = ta; sel_top_b = tb; access_reg = acr;
        @(negedge clk);
        op_valid = 1'b0;
        ok = acr[0] && (op <= 3'd4);
        chk({req, " undef_exc"}, 64'(undef_exc), 64'(!ok));
        chk({req, " rd_valid"}, 64'(rd_valid), 64'(ok && op == 3'd4));
        if (ok) begin
            case (op)
                3'd0, 3'd1, 3'd2: model = model + want_addend(op, a, b, ta, tb);
                3'd3:             model = {b[7:0], a};
                3'd4: begin
                    chk({req, " rd_lo"}, 64'(rd_lo), 64'(model[31:0]));
                    chk({req, " rd_hi"}, 64'(rd_hi), 64'(want_hi(model)));
                end
                default: ;
            endcase
        end
    endtask

    task automatic do_read(input string req);
        run_op(req, 3'd4, '0, '0, 1'b0, 1'b0, 16'h0001);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] save_lo, save_hi;
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        chk("R1 undef in reset", 64'(undef_exc), 64'd0);
        chk("R1 rd_valid in reset", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        do_read("R1 cleared");

        // R2 full word, mixed signs
        run_op("R2 full", 3'd0, 32'hFFFF_FFFD, 32'd7, 0, 0, 16'h0001);
        run_op("R2 full", 3'd0, 32'h8000_0000, 32'h8000_0000, 0, 0, 16'h0001);
        do_read("R2 result");
        // R3 packed
        run_op("R3 dual", 3'd1, 32'h8000_7FFF, 32'h8000_7FFF, 0, 0, 16'h0001);
        run_op("R3 dual", 3'd1, 32'hFFFE_0003, 32'h0005_FFFC, 0, 0, 16'h0001);
        do_read("R3 result");
        // R4 all four select combinations
        for (int s = 0; s < 4; s++) begin
            run_op("R4 select", 3'd2, 32'hFFF0_0011, 32'h0003_FFF9, s[1], s[0], 16'h0001);
            do_read("R4 result");
        end
        // R5 load, R6 negative read
        run_op("R5 load", 3'd3, 32'h1234_5678, 32'hAAAA_AA9C, 0, 0, 16'h0001);
        do_read("R6 neg read");
        chk("R6 rd_hi sext", 64'(rd_hi), 64'hFFFF_FF9C);
        // R6 hold between reads
        @(negedge clk);
        chk("R6 hold lo", 64'(rd_lo), 64'h1234_5678);
        // R10 wrap
        run_op("R10 load", 3'd3, 32'hFFFF_FFFF, 32'h0000_007F, 0, 0, 16'h0001);
        run_op("R10 add", 3'd0, 32'd1, 32'd1, 0, 0, 16'h0001);
        do_read("R10 wrap");
        chk("R10 hi", 64'(rd_hi), 64'hFFFF_FF80);
        run_op("R10 load", 3'd3, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, 16'h0001);
        run_op("R10 add", 3'd0, 32'd1, 32'd1, 0, 0, 16'h0001);
        do_read("R10 wrap zero");
        chk("R10 zero", 64'(rd_lo), 64'd0);
        // R7 blocked ops, with other bits set
        run_op("R5 load", 3'd3, 32'hCAFE_0001, 32'h0000_0042, 0, 0, 16'h0001);
        run_op("R7 blocked mac", 3'd0, 32'd99, 32'd99, 0, 0, 16'hFFFE);
        run_op("R7 blocked load", 3'd3, 32'd5, 32'd6, 0, 0, 16'h0000);
        run_op("R7 blocked read", 3'd4, 32'd0, 32'd0, 0, 0, 16'h8000);
        do_read("R7 unchanged");
        // R8 unassigned codes
        for (int c = 5; c < 8; c++) run_op("R8 unassigned", 3'(c), 32'd3, 32'd3, 0, 0, 16'h0001);
        do_read("R8 unchanged");
        // R12 other bits ignored when granted
        run_op("R12 extra bits", 3'd0, 32'd1000, 32'hFFFF_FFFF, 0, 0, 16'hFFFF);
        do_read("R12 result");
        // R9 idle with data wiggling
        @(negedge clk);
        src_a = 32'h7777_7777; src_b = 32'h7777_7777; op_code = 3'd3; access_reg = 16'h0001;
        repeat (3) begin
            @(negedge clk);
            chk("R9 idle undef", 64'(undef_exc), 64'd0);
            chk("R9 idle rd_valid", 64'(rd_valid), 64'd0);
        end
        do_read("R9 unchanged");
        // R11 save, disturb, restore
        do_read("R11 save");
        save_lo = rd_lo; save_hi = rd_hi;
        run_op("R11 disturb", 3'd1, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 16'h0001);
        run_op("R11 restore", 3'd3, save_lo, save_hi, 0, 0, 16'h0001);
        do_read("R11 restored");
        chk("R11 lo", 64'(rd_lo), 64'(save_lo));
        chk("R11 hi", 64'(rd_hi), 64'(save_hi));
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  op;
            logic [15:0] acr;
            op  = 3'($urandom % 8);
            acr = 16'($urandom);
            if ($urandom % 6 != 0) acr[0] = 1'b1;
            else acr[0] = 1'b0;
            run_op("R2 R3 R4 R5 R6 R7 R8 random", op, $urandom, $urandom,
                   1'($urandom), 1'($urandom), acr);
            if (i % 8 == 7) do_read("R6 random read");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule